// File: doc/BRIEF.md
# DDR Bank Read Timing Tracker

This block sits beside a DDR SDRAM command bus that serves four banks and watches every command issued on it. For each bank it follows the life cycle from idle, through row opening, to open. From an open bank it follows either an explicit close or a read that closes the row by itself. It reports which banks will accept a column command right now. When a command arrives too early, or reaches a bank that is busy, it raises a single-cycle violation pulse.

For every read it accepts, the block predicts the cycles in which read data occupies the bus. It does this from the programmed CAS latency and burst length. The bus carries two beats per clock. The window is therefore half the burst length in clocks long, and a beat index labels the first beat of each clock. A module-mode flag covers an extra register stage on the data path. That stage adds one cycle to the read latency and one cycle to the start of a self-closing read's internal precharge.

Top module: `ddr_bank_rd_tracker`

## Requirements
- R1: While `rst_n` is low and directly after it, every bank is idle, `bank_ready` is all zero, and `viol` and `rd_valid` are low.
- R2: An activate (`cmd_act`) to an idle bank starts row opening. A read or write to that bank is legal at the clock edge `cfg_trcd` cycles after the activate edge, or later. `bank_ready[b]` is high from the cycle before that edge onward. A column command sent earlier, or sent to an idle bank, is a violation and changes nothing.
- R3: `viol` is registered. It is high for exactly the cycle after an edge that sampled an illegal command. Asserting more than one strobe at one edge is illegal, and no bank changes state.
- R4: A legal read sampled at edge t raises `rd_valid` at edge t+L. L is `cfg_cl`, with 0 treated as 1, plus one when `cfg_module` is 1.
- R5: A burst keeps `rd_valid` high for BL/2 cycles, with `rd_beat` stepping 0, 2, 4, 6. `cfg_bl` encodes BL: 0 means 2, 1 means 4, 2 or 3 means 8. Between bursts `rd_beat` is 0.
- R6: Reads to different open banks issued BL/2 cycles apart produce one unbroken `rd_valid` run. `rd_beat` wraps to 0 where the second burst begins.
- R7: If a new burst's first cycle falls inside a running burst, the old burst ends there. `rd_beat` restarts at 0 and the new burst runs its full length.
- R8: A read with `ap_bit` high closes the bank by itself. Internal precharge begins BL/2 cycles after the read, or BL/2+1 in module mode. Until the bank may be activated again, any read, write, precharge or activate to it is a violation.
- R9: After a self-closing read at edge t, an activate to that bank is legal at edge t+D+`cfg_trp`, where D is the delay of R8. At one edge earlier it is a violation.
- R10: A precharge (`cmd_pre`) to an open bank closes it, and an activate is legal `cfg_trp` edges later. A precharge to an idle bank is legal and has no effect.
- R11: An activate to a bank that is not idle is a violation. A legal write keeps the bank open, ignores `ap_bit` and produces no read window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_act | input | 1 | Activate strobe |
| cmd_rd | input | 1 | Read strobe |
| cmd_wr | input | 1 | Write strobe |
| cmd_pre | input | 1 | Precharge strobe |
| bank_addr | input | 2 | Target bank of the command |
| ap_bit | input | 1 | Self-closing flag, sampled with a read |
| cfg_cl | input | 3 | Device CAS latency in cycles |
| cfg_bl | input | 2 | Burst length code |
| cfg_trcd | input | 4 | Activate-to-column delay in cycles |
| cfg_trp | input | 4 | Precharge period in cycles |
| cfg_module | input | 1 | Adds one cycle of latency and precharge lead |
| bank_ready | output | 4 | Bank accepts a read or write at the next edge |
| viol | output | 1 | One-cycle violation pulse |
| rd_valid | output | 1 | Read data on the bus this cycle |
| rd_beat | output | 3 | Index of the first beat carried this cycle |

## Verification
Two functions can fall in the same cycle. The first cycle of a new burst can coincide with a running burst's continuation, and the data path must let the newer one win. The bench provokes this with reads to two banks issued closer together than BL/2 cycles, and it judges the result from the beat sequence: the beat index must restart at 0 exactly at the new read's latency. It also places an activate one edge before and exactly at the end of a self-closing read's precharge. This separates the blocked state from the freed state on adjacent cycles.

// File: rtl/ddrt_pkg.sv
package ddrt_pkg;

  localparam int CL_W    = 3;
  localparam int LAT_W   = CL_W + 1;
  localparam int MAX_LAT = 1 << CL_W;
  localparam int BLC_W   = 2;
  localparam int BEAT_W  = 3;

  typedef enum logic [2:0] {
    BK_IDLE    = 3'd0,
    BK_OPENING = 3'd1,
    BK_OPEN    = 3'd2,
    BK_AP_WAIT = 3'd3,
    BK_CLOSING = 3'd4
  } bank_st_e;

  // beats in one burst for a burst code
  function automatic logic [3:0] burst_beats(input logic [BLC_W-1:0] code);
    case (code)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // bus cycles occupied by one burst (two beats per cycle)
  function automatic logic [2:0] burst_cycles(input logic [BLC_W-1:0] code);
    logic [3:0] b;
    b = burst_beats(code);
    return b[3:1];
  endfunction

  // cycles from a self-closing read to the start of internal precharge
  function automatic logic [3:0] ap_lead(input logic [BLC_W-1:0] code, input logic module_mode);
    return {1'b0, burst_cycles(code)} + {3'b000, module_mode};
  endfunction

  // cycles from a read to its first data cycle
  function automatic logic [LAT_W-1:0] read_latency(input logic [CL_W-1:0] cl, input logic module_mode);
    logic [CL_W-1:0] c;
    c = (cl == '0) ? CL_W'(1) : cl;
    return {1'b0, c} + LAT_W'(module_mode);
  endfunction

  // load value for a countdown that must expire after n cycles (n of 0 acts as 1)
  function automatic logic [7:0] span_load(input logic [7:0] n);
    return (n == 8'd0) ? 8'd0 : n - 8'd1;
  endfunction

endpackage

// File: rtl/ddrt_decode.sv
module ddrt_decode #(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input  logic          cmd_act,
  input  logic          cmd_rd,
  input  logic          cmd_wr,
  input  logic          cmd_pre,
  input  logic [BW-1:0] bank_addr,
  output logic          multi,
  output logic [NB-1:0] sel_act,
  output logic [NB-1:0] sel_rd,
  output logic [NB-1:0] sel_wr,
  output logic [NB-1:0] sel_pre
);
  logic [2:0] n_strobe;

  always_comb begin
    n_strobe = 3'($countones({cmd_act, cmd_rd, cmd_wr, cmd_pre}));
    multi    = (n_strobe > 3'd1);
  end

  for (genvar b = 0; b < NB; b++) begin : g_sel
    logic hit;
    assign hit        = !multi && (bank_addr == BW'(b));
    assign sel_act[b] = hit && cmd_act;
    assign sel_rd[b]  = hit && cmd_rd;
    assign sel_wr[b]  = hit && cmd_wr;
    assign sel_pre[b] = hit && cmd_pre;
  end

endmodule

// File: rtl/ddrt_bank.sv
module ddrt_bank
  import ddrt_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_act,
  input  logic          sel_rd,
  input  logic          sel_wr,
  input  logic          sel_pre,
  input  logic          ap,
  input  logic [TW-1:0] trcd,
  input  logic [TW-1:0] trp,
  input  logic [TW-1:0] lead,
  output logic          rd_ok,
  output logic          illegal,
  output logic          rd_take,
  output logic          ap_busy
);
  bank_st_e      st_q;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] trcd_ld, trp_ld, lead_ld;
  logic          expired, open_now, free_now, pre_ok;

  always_comb begin
    trcd_ld  = TW'(span_load(8'(trcd)));
    trp_ld   = TW'(span_load(8'(trp)));
    lead_ld  = TW'(span_load(8'(lead)));
    expired  = (cnt_q == '0);
    open_now = (st_q == BK_OPEN) || (st_q == BK_OPENING && expired);
    free_now = (st_q == BK_IDLE) || (st_q == BK_CLOSING && expired);
    pre_ok   = (st_q == BK_IDLE) || open_now;
    illegal  = (sel_act && !free_now) || ((sel_rd || sel_wr) && !open_now)
             || (sel_pre && !pre_ok);
    rd_take  = sel_rd && open_now;
    rd_ok    = open_now;
    ap_busy  = (st_q == BK_AP_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        BK_IDLE: begin
          if (sel_act) begin
            st_q  <= BK_OPENING;
            cnt_q <= trcd_ld;
          end
        end
        BK_OPENING, BK_OPEN: begin
          if (rd_take && ap) begin
            st_q  <= BK_AP_WAIT;
            cnt_q <= lead_ld;
          end else if (sel_pre && open_now) begin
            st_q  <= BK_CLOSING;
            cnt_q <= trp_ld;
          end else if (st_q == BK_OPENING) begin
            if (expired) st_q <= BK_OPEN;
            else         cnt_q <= cnt_q - 1'b1;
          end
        end
        BK_AP_WAIT: begin
          if (expired) begin
            st_q  <= BK_CLOSING;
            cnt_q <= trp_ld;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        BK_CLOSING: begin
          if (sel_act && expired) begin
            st_q  <= BK_OPENING;
            cnt_q <= trcd_ld;
          end else if (expired) begin
            st_q <= BK_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= BK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ddrt_rdpipe.sv
module ddrt_rdpipe
  import ddrt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [LAT_W-1:0]  lat,
  input  logic [2:0]        half,
  output logic              valid,
  output logic [BEAT_W-1:0] beat
);
  localparam int IW = $clog2(MAX_LAT);

  logic [MAX_LAT-1:0] sr_q;
  logic [IW-1:0]      tap;
  logic               start;
  logic [2:0]         left_q;

  always_comb begin
    tap   = IW'(lat - LAT_W'(1));
    start = sr_q[tap];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      valid  <= 1'b0;
      beat   <= '0;
      left_q <= '0;
    end else begin
      sr_q <= {sr_q[MAX_LAT-2:0], launch};
      if (start) begin
        valid  <= 1'b1;
        beat   <= '0;
        left_q <= half - 3'd1;
      end else if (valid && left_q != 3'd0) begin
        beat   <= beat + BEAT_W'(2);
        left_q <= left_q - 3'd1;
      end else begin
        valid <= 1'b0;
        beat  <= '0;
      end
    end
  end

endmodule

// File: rtl/ddr_bank_rd_tracker.sv
module ddr_bank_rd_tracker
  import ddrt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TIME_W    = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_act,
  input  logic                 cmd_rd,
  input  logic                 cmd_wr,
  input  logic                 cmd_pre,
  input  logic [BANK_W-1:0]    bank_addr,
  input  logic                 ap_bit,
  input  logic [CL_W-1:0]      cfg_cl,
  input  logic [BLC_W-1:0]     cfg_bl,
  input  logic [TIME_W-1:0]    cfg_trcd,
  input  logic [TIME_W-1:0]    cfg_trp,
  input  logic                 cfg_module,
  output logic [NUM_BANKS-1:0] bank_ready,
  output logic                 viol,
  output logic                 rd_valid,
  output logic [BEAT_W-1:0]    rd_beat
);
  logic                 multi;
  logic [NUM_BANKS-1:0] sel_act, sel_rd, sel_wr, sel_pre;
  logic [NUM_BANKS-1:0] bank_illegal, rd_take, ap_busy;
  logic [TIME_W-1:0]    lead;
  logic [LAT_W-1:0]     lat;
  logic [2:0]           half;
  logic                 launch;

  always_comb begin
    lead   = TIME_W'(ap_lead(cfg_bl, cfg_module));
    lat    = read_latency(cfg_cl, cfg_module);
    half   = burst_cycles(cfg_bl);
    launch = |rd_take;
  end

  ddrt_decode #(.NB(NUM_BANKS), .BW(BANK_W)) u_dec (
    .cmd_act   (cmd_act),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .cmd_pre   (cmd_pre),
    .bank_addr (bank_addr),
    .multi     (multi),
    .sel_act   (sel_act),
    .sel_rd    (sel_rd),
    .sel_wr    (sel_wr),
    .sel_pre   (sel_pre)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddrt_bank #(.TW(TIME_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_act (sel_act[b]),
      .sel_rd  (sel_rd[b]),
      .sel_wr  (sel_wr[b]),
      .sel_pre (sel_pre[b]),
      .ap      (ap_bit),
      .trcd    (cfg_trcd),
      .trp     (cfg_trp),
      .lead    (lead),
      .rd_ok   (bank_ready[b]),
      .illegal (bank_illegal[b]),
      .rd_take (rd_take[b]),
      .ap_busy (ap_busy[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) viol <= 1'b0;
    else        viol <= multi || (|bank_illegal);
  end

  ddrt_rdpipe u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .lat    (lat),
    .half   (half),
    .valid  (rd_valid),
    .beat   (rd_beat)
  );

endmodule

// File: rtl/ddrt_checker.sv
module ddrt_checker
  import ddrt_pkg::*;
#(
  parameter int NB = 4,
  localparam int BW = $clog2(NB)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_act,
  input logic              cmd_rd,
  input logic              cmd_wr,
  input logic              cmd_pre,
  input logic [BW-1:0]     bank_addr,
  input logic [BLC_W-1:0]  cfg_bl,
  input logic [NB-1:0]     bank_ready,
  input logic              viol,
  input logic              rd_valid,
  input logic [BEAT_W-1:0] rd_beat,
  input logic [NB-1:0]     rd_take,
  input logic [NB-1:0]     ap_busy
);

  p_multi_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({cmd_act, cmd_rd, cmd_wr, cmd_pre}) > 1) |=> viol);

  p_early_col_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && !cmd_act && !cmd_wr && !cmd_pre && !bank_ready[bank_addr]) |=> viol);

  p_burst_opens_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (rd_beat == '0));

  p_beat_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |-> (rd_beat == '0 || rd_beat == $past(rd_beat) + BEAT_W'(2)));

  p_burst_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> ({1'b0, $past(rd_beat)} == burst_beats(cfg_bl) - 4'd2));

  p_ap_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take & ap_busy) == '0);

endmodule

bind ddr_bank_rd_tracker ddrt_checker #(.NB(NUM_BANKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_act    (cmd_act),
  .cmd_rd     (cmd_rd),
  .cmd_wr     (cmd_wr),
  .cmd_pre    (cmd_pre),
  .bank_addr  (bank_addr),
  .cfg_bl     (cfg_bl),
  .bank_ready (bank_ready),
  .viol       (viol),
  .rd_valid   (rd_valid),
  .rd_beat    (rd_beat),
  .rd_take    (rd_take),
  .ap_busy    (ap_busy)
);

// File: tb/tb_ddr_bank_rd_tracker.sv
`timescale 1ns/1ps
module tb_ddr_bank_rd_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_act = 0, cmd_rd = 0, cmd_wr = 0, cmd_pre = 0, ap_bit = 0;
  logic [1:0] bank_addr = 0;
  logic [2:0] cfg_cl = 3'd2;
  logic [1:0] cfg_bl = 2'd2;
  logic [3:0] cfg_trcd = 4'd3, cfg_trp = 4'd3;
  logic       cfg_module = 1'b0;
  logic [3:0] bank_ready;
  logic       viol, rd_valid;
  logic [2:0] rd_beat;

  always #2 clk = ~clk;

  ddr_bank_rd_tracker dut (
    .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_pre(cmd_pre), .bank_addr(bank_addr), .ap_bit(ap_bit), .cfg_cl(cfg_cl),
    .cfg_bl(cfg_bl), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_module(cfg_module),
    .bank_ready(bank_ready), .viol(viol), .rd_valid(rd_valid), .rd_beat(rd_beat)
  );

  int checks = 0, errors = 0, ncyc = 0, last_t = 0, nxt = 0;
  bit done = 0;
  bit       vh[4096];
  bit       violh[4096];
  bit [2:0] bh[4096];
  bit [3:0] rdyh[4096];

  // history: entry k holds the outputs seen after clock edge k
  always @(negedge clk) begin
    vh[ncyc % 4096]    = rd_valid;
    bh[ncyc % 4096]    = rd_beat;
    violh[ncyc % 4096] = viol;
    rdyh[ncyc % 4096]  = bank_ready;
    ncyc++;
  end

  function automatic int exp_lat(int cl, int md);
    return ((cl == 0) ? 1 : cl) + md;
  endfunction
  function automatic int exp_beats(int code);
    return (code == 0) ? 2 : (code == 1) ? 4 : 8;
  endfunction
  function automatic int exp_lead(int code, int md);
    return exp_beats(code) / 2 + md;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(bit a, bit r, bit w, bit p, int bk, bit ap);
    cmd_act = a; cmd_rd = r; cmd_wr = w; cmd_pre = p;
    bank_addr = 2'(bk); ap_bit = ap;
    @(posedge clk);
    last_t = ncyc;
    @(negedge clk);
    #1;
    cmd_act = 0; cmd_rd = 0; cmd_wr = 0; cmd_pre = 0; ap_bit = 0;
    nxt = last_t + 1;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) issue(0, 0, 0, 0, 0, 0);
  endtask

  task automatic go_to(int t);
    while (nxt < t) issue(0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 ready in reset", int'(bank_ready), 0);
    chk("R1 viol in reset", int'(viol), 0);
    chk("R1 valid in reset", int'(rd_valid), 0);
    rst_n = 1;
    nxt = ncyc;
  endtask

  // burst check: quiet before latency, then half-length window, then quiet
  task automatic check_burst(int t, int lat, int beats);
    chk("R4 quiet before latency", int'(vh[(t + lat - 1) % 4096]), 0);
    for (int j = 0; j < beats / 2; j++) begin
      chk("R4 valid in window", int'(vh[(t + lat + j) % 4096]), 1);
      chk("R5 beat index", int'(bh[(t + lat + j) % 4096]), 2 * j);
    end
    chk("R5 burst ends", int'(vh[(t + lat + beats / 2) % 4096]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ta, t, t1, t2, t3, tp;
    void'($urandom(32'd20240611));
    do_reset();

    // R2 / R3 / R4 / R5: early read, then legal read
    issue(1, 0, 0, 0, 0, 0); ta = last_t;
    issue(0, 1, 0, 0, 0, 0); t1 = last_t;
    nop(1); t2 = last_t;
    issue(0, 1, 0, 0, 0, 0); t3 = last_t;
    nop(12);
    chk("R2 act legal", int'(violh[ta % 4096]), 0);
    chk("R2 early read flagged", int'(violh[t1 % 4096]), 1);
    chk("R3 pulse one cycle", int'(violh[t2 % 4096]), 0);
    chk("R2 not ready early", int'(rdyh[t1 % 4096][0]), 0);
    chk("R2 ready after trcd", int'(rdyh[t2 % 4096][0]), 1);
    chk("R2 read legal", int'(violh[t3 % 4096]), 0);
    check_burst(t3, 2, 8);

    // R8 / R9: self-closing read in module mode, BL4
    cfg_module = 1; cfg_bl = 2'd1;
    issue(1, 0, 0, 0, 1, 0); ta = last_t;
    nop(2);
    issue(0, 1, 0, 0, 1, 1); t = last_t;
    issue(0, 1, 0, 0, 1, 0);
    issue(0, 0, 0, 1, 1, 0);
    nop(2);
    issue(1, 0, 0, 0, 1, 0);
    issue(1, 0, 0, 0, 1, 0);
    nop(2);
    chk("R8 ap read legal", int'(violh[t % 4096]), 0);
    chk("R8 read while closing", int'(violh[(t + 1) % 4096]), 1);
    chk("R8 pre while closing", int'(violh[(t + 2) % 4096]), 1);
    chk("R9 act one early", int'(violh[(t + 5) % 4096]), 1);
    chk("R9 act on time", int'(violh[(t + 6) % 4096]), 0);
    check_burst(t, 3, 4);

    // R6: interleaved reads, BL8, no module stage
    cfg_module = 0; cfg_bl = 2'd2;
    issue(1, 0, 0, 0, 2, 0);
    issue(1, 0, 0, 0, 3, 0);
    nop(3);
    issue(0, 1, 0, 0, 2, 0); t = last_t;
    nop(3);
    issue(0, 1, 0, 0, 3, 0);
    nop(12);
    for (int j = 0; j < 8; j++) begin
      chk("R6 gapless valid", int'(vh[(t + 2 + j) % 4096]), 1);
      chk("R6 beat wraps", int'(bh[(t + 2 + j) % 4096]), (2 * j) % 8);
    end
    chk("R6 run ends", int'(vh[(t + 10) % 4096]), 0);

    // R7: overlapping bursts, the newer one cuts in
    issue(0, 1, 0, 0, 2, 0); t = last_t;
    nop(1);
    issue(0, 1, 0, 0, 3, 0);
    nop(12);
    chk("R7 first beat", int'(bh[(t + 2) % 4096]), 0);
    chk("R7 second beat", int'(bh[(t + 3) % 4096]), 2);
    chk("R7 restart", int'(bh[(t + 4) % 4096]), 0);
    chk("R7 restart valid", int'(vh[(t + 4) % 4096]), 1);
    chk("R7 full new burst", int'(bh[(t + 7) % 4096]), 6);
    chk("R7 end", int'(vh[(t + 8) % 4096]), 0);

    // R10: explicit precharge
    issue(0, 0, 0, 1, 2, 0); t = last_t;
    nop(1);
    issue(1, 0, 0, 0, 2, 0);
    issue(1, 0, 0, 0, 2, 0);
    chk("R10 pre legal", int'(violh[t % 4096]), 0);
    chk("R10 closed not ready", int'(rdyh[t % 4096][2]), 0);
    chk("R10 act early", int'(violh[(t + 2) % 4096]), 1);
    chk("R10 act after trp", int'(violh[(t + 3) % 4096]), 0);
    issue(0, 0, 0, 1, 3, 0); tp = last_t;
    nop(4);
    issue(0, 0, 0, 1, 3, 0);
    chk("R10 pre to idle legal", int'(violh[last_t % 4096]), 0);
    chk("R10 pre to idle no effect", int'(rdyh[last_t % 4096][3]), 0);

    // R3: two strobes at once change nothing
    issue(1, 0, 0, 1, 3, 0);
    chk("R3 multi strobe flagged", int'(violh[last_t % 4096]), 1);
    nop(5);
    chk("R3 multi strobe no act", int'(rdyh[last_t % 4096][3]), 0);
    issue(1, 0, 0, 0, 3, 0);
    chk("R3 bank stayed idle", int'(violh[last_t % 4096]), 0);

    // R11: act on busy bank, write ignores A10
    nop(3);
    issue(1, 0, 0, 0, 3, 0);
    chk("R11 act on open bank", int'(violh[last_t % 4096]), 1);
    issue(0, 0, 1, 0, 3, 1); t = last_t;
    nop(12);
    chk("R11 write legal", int'(violh[t % 4096]), 0);
    for (int j = 1; j <= 10; j++)
      chk("R11 write no window", int'(vh[(t + j) % 4096]), 0);
    chk("R11 write keeps open", int'(rdyh[last_t % 4096][3]), 1);

    // random phase
    do_reset();
    for (int it = 0; it < 150; it++) begin
      int cl, md, blc, trcd, trp, bk, lat, beats, lead, tgt, k;
      bit ap;
      cl = $urandom % 8; md = $urandom % 2; blc = $urandom % 4;
      trcd = 1 + $urandom % 6; trp = 1 + $urandom % 6;
      bk = it % 4; ap = $urandom % 2;
      cfg_cl = 3'(cl); cfg_module = md[0]; cfg_bl = 2'(blc);
      cfg_trcd = 4'(trcd); cfg_trp = 4'(trp);
      lat = exp_lat(cl, md); beats = exp_beats(blc); lead = exp_lead(blc, md);
      issue(1, 0, 0, 0, bk, 0); ta = last_t;
      chk("R2 random act", int'(violh[ta % 4096]), 0);
      if (trcd > 1 && ($urandom % 2) == 1) begin
        k = 1 + $urandom % (trcd - 1);
        go_to(ta + k);
        issue(0, 1, 0, 0, bk, 0);
        chk("R2 random early read", int'(violh[last_t % 4096]), 1);
      end
      go_to(ta + trcd + ($urandom % 3));
      issue(0, 1, 0, 0, bk, ap); t = last_t;
      chk("R2 random read legal", int'(violh[t % 4096]), 0);
      if (ap) begin
        tgt = t + lead + trp;
        if (nxt <= tgt - 1) begin
          go_to(tgt - 1);
          issue(1, 0, 0, 0, bk, 0);
          chk("R9 random act early", int'(violh[last_t % 4096]), 1);
        end
        go_to(tgt);
        issue(1, 0, 0, 0, bk, 0);
        chk("R9 random act on time", int'(violh[last_t % 4096]), 0);
        nop(trcd);
      end
      issue(0, 0, 0, 1, bk, 0);
      chk("R10 random pre", int'(violh[last_t % 4096]), 0);
      nop(trp + 12);
      check_burst(t, lat, beats);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule